// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Source Promotion

This block chooses which single pending interrupt request the processor should service next. It sees two groups of requests. Nonmaskable sources have a fixed order among themselves. Maskable sources are one external level-sensitive pin and a set of peripheral lines, each with a flag and a local enable. The result is a request-valid strobe, a flag that tells whether the winner is nonmaskable, and the 16-bit vector address of the winner's handler.

The block also holds the two processor mask bits. The global maskable mask is called I here, and the separate mask for the external nonmaskable pin is called X. It applies their reset, software-write, interrupt-entry and return-from-interrupt rules. A promotion register lets software lift one chosen maskable source above all other maskable sources. The value written is the low byte of that source's vector. Stacking, instruction flow and fetching the vector from memory are handled by the processor.

Maskable source k has vector low byte `MASK_TOP - 2k`. With the defaults, source 0 is the external pin at 0xF2 and sources 1..7 are the peripherals at 0xF0 down to 0xE4. Nonmaskable source j has low byte `NMI_TOP - 2j`: 0xF8, 0xF6 and 0xF4. The vector address is `{VEC_PAGE, low byte}` with VEC_PAGE = 0xFF.

Top module: `irq_arbiter`

## Requirements
- R1: Any enabled nonmaskable request outranks every maskable request. Among nonmaskable sources, the lower index (the higher vector address) wins. The winner's vector is 0xFF00 | (0xF8 - 2j) and it is flagged on `irq_nmi`.
- R2: While I = 1, no maskable source produces a request. Peripheral source k (k >= 1) requests only when both `per_flag[k-1]` and `per_en[k-1]` are 1.
- R3: X = 1 blocks only nonmaskable source `XPIN_IDX` (index 2, vector 0xFFF4). The other nonmaskable sources request regardless of X.
- R4: Reset sets X = 1 and I = 1, sets the promotion register to 0xF2, and sets `irq_valid` to 0.
- R5: A software write (`ccr_wr`) can clear X but never set it, while it writes I freely. When the processor takes a nonmaskable interrupt (`cpu_take` while `irq_valid` and `irq_nmi` are high), both X and I become 1. Taking a maskable interrupt sets only I.
- R6: The external maskable pin is active-high when `ext_pol` = 1 and active-low when `ext_pol` = 0. It is a level, not an edge.
- R7: The promoted maskable source, when it requests, beats all other maskable sources. The remaining maskable sources are ordered by index, with a lower index (higher vector address) winning.
- R8: A promotion write is accepted only while I = 1, and only if bits [7:1] of the data match the vector low byte of a maskable source. Other writes leave the register unchanged. Bit 0 always reads 0.
- R9: `irq_valid`, `irq_nmi` and `irq_vector` are registered. They reflect the inputs and state seen at the previous clock edge. `irq_vector` is 0 when `irq_valid` is 0.
- R10: A return pulse (`rti_en`) loads I from `rti_i`. It loads X with X AND `rti_x`, so the return can restore a cleared X but never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_src | input | NUM_NMI | Nonmaskable request lines, index 0 highest |
| ext_irq | input | 1 | External maskable pin level |
| ext_pol | input | 1 | Pin polarity: 1 active-high, 0 active-low |
| per_flag | input | NUM_MASK-1 | Peripheral event flags for maskable sources 1..N-1 |
| per_en | input | NUM_MASK-1 | Peripheral local enables for maskable sources 1..N-1 |
| ccr_wr | input | 1 | Software write strobe for the mask bits |
| ccr_x_wd | input | 1 | X value written (only 0 has effect) |
| ccr_i_wd | input | 1 | I value written |
| rti_en | input | 1 | Return-from-interrupt restore strobe |
| rti_x | input | 1 | Saved X value |
| rti_i | input | 1 | Saved I value |
| cpu_take | input | 1 | Processor accepts the presented interrupt |
| prom_wr | input | 1 | Promotion register write strobe |
| prom_wdata | input | 8 | Promotion write data (vector low byte) |
| prom_q | output | 8 | Promotion register value, bit 0 zero |
| mask_x | output | 1 | X mask bit |
| mask_i | output | 1 | I mask bit |
| irq_valid | output | 1 | An interrupt is presented |
| irq_nmi | output | 1 | The presented interrupt is nonmaskable |
| irq_vector | output | 16 | Vector address of the presented interrupt |

## Verification
A wrong mask bit shows up at the vector output on the first edge after the state goes wrong. A stuck or re-set X hides or exposes the 0xFFF4 source, and a wrong I lets maskable vectors through or suppresses them. A corrupt promotion register shows up directly on `prom_q`. It also shows up as the wrong maskable winner, but only when the promoted source and a higher-ordered source request together, so the bench creates exactly that overlap. The mask bits are read straight after each write, take and return pulse, and each output expectation is compared one edge after its stimulus.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // Low byte of the vector for a source at position idx counted down from top.
   function automatic logic [7:0] vec_lo(input logic [7:0] top, input int idx);
      return top - 8'(2 * idx);
   endfunction

endpackage

// File: rtl/irq_mask_bits.sv
module irq_mask_bits (
   input  logic clk,
   input  logic rst,
   input  logic take_nmi,
   input  logic take_msk,
   input  logic rti_en,
   input  logic rti_x,
   input  logic rti_i,
   input  logic sw_wr,
   input  logic sw_x,
   input  logic sw_i,
   output logic x_q,
   output logic i_q
);

   // Priority: interrupt entry, then return restore, then software write.
   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= 1'b1;
         i_q <= 1'b1;
      end else if (take_nmi) begin
         x_q <= 1'b1;
         i_q <= 1'b1;
      end else if (take_msk) begin
         i_q <= 1'b1;
      end else if (rti_en) begin
         x_q <= x_q & rti_x;
         i_q <= rti_i;
      end else if (sw_wr) begin
         x_q <= x_q & sw_x;
         i_q <= sw_i;
      end
   end

   assert_reset_masks_R4: assert property (@(posedge clk) rst |=> (x_q && i_q))
      else $error("masks not set by reset");
   assert_x_hw_only_R5: assert property (@(posedge clk) disable iff (rst)
      (!x_q && !take_nmi) |=> !x_q)
      else $error("X set without nonmaskable entry");
   assert_i_on_entry_R5: assert property (@(posedge clk) disable iff (rst)
      (take_nmi || take_msk) |=> i_q)
      else $error("I not set on interrupt entry");
   assert_x_on_nmi_R5: assert property (@(posedge clk) disable iff (rst)
      take_nmi |=> x_q)
      else $error("X not set on nonmaskable entry");

endmodule

// File: rtl/irq_prom_reg.sv
module irq_prom_reg
   import irq_arb_pkg::*;
#(
   parameter int         NUM_MASK = 8,
   parameter logic [7:0] MASK_TOP = 8'hF2,
   localparam int        IDXW     = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr,
   input  logic [7:0]      wdata,
   input  logic            i_bit,
   output logic [7:0]      prom_q,
   output logic [IDXW-1:0] prom_idx
);

   logic [6:0]          sel_q;
   logic [NUM_MASK-1:0] hit;
   logic                unused_wbit;

   assign unused_wbit = wdata[0];

   // One comparator per maskable vector.
   for (genvar k = 0; k < NUM_MASK; k++) begin : g_match
      localparam logic [7:0] LO = vec_lo(MASK_TOP, k);
      assign hit[k] = (wdata[7:1] == LO[7:1]);
   end

   always_ff @(posedge clk) begin
      if (rst)
         sel_q <= MASK_TOP[7:1];
      else if (wr && i_bit && (|hit))
         sel_q <= wdata[7:1];
   end

   assign prom_q = {sel_q, 1'b0};

   // Turn the stored byte back into a source index.
   always_comb begin
      prom_idx = '0;
      for (int k = 0; k < NUM_MASK; k++) begin
         if (sel_q == vec_lo(MASK_TOP, k) >> 1)
            prom_idx = IDXW'(k);
      end
   end

   assert_prom_locked_R8: assert property (@(posedge clk) disable iff (rst)
      !i_bit |=> $stable(prom_q))
      else $error("promotion changed while I clear");
   assert_prom_bad_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (wr && !(|hit)) |=> $stable(prom_q))
      else $error("promotion took an unmatched value");

endmodule

// File: rtl/irq_nmi_pick.sv
module irq_nmi_pick
   import irq_arb_pkg::*;
#(
   parameter int         NUM_NMI  = 3,
   parameter int         XPIN_IDX = 2,
   parameter logic [7:0] NMI_TOP  = 8'hF8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_NMI-1:0] src,
   input  logic               x_bit,
   output logic               valid,
   output logic [7:0]         lo
);

   logic [NUM_NMI-1:0] eff;

   // Only the external pin source is gated by X.
   for (genvar j = 0; j < NUM_NMI; j++) begin : g_gate
      if (j == XPIN_IDX) begin : g_pin
         assign eff[j] = src[j] & ~x_bit;
      end else begin : g_free
         assign eff[j] = src[j];
      end
   end

   always_comb begin
      valid = 1'b0;
      lo    = '0;
      for (int j = NUM_NMI - 1; j >= 0; j--) begin
         if (eff[j]) begin
            valid = 1'b1;
            lo    = vec_lo(NMI_TOP, j);
         end
      end
   end

   assert_x_gates_pin_R3: assert property (@(posedge clk) disable iff (rst)
      (x_bit && src == (NUM_NMI'(1) << XPIN_IDX)) |-> !valid)
      else $error("pin nonmaskable passed while X set");
   assert_top_nmi_R1: assert property (@(posedge clk) disable iff (rst)
      src[0] |-> (valid && lo == NMI_TOP))
      else $error("highest nonmaskable lost");

endmodule

// File: rtl/irq_msk_pick.sv
module irq_msk_pick
   import irq_arb_pkg::*;
#(
   parameter int         NUM_MASK = 8,
   parameter logic [7:0] MASK_TOP = 8'hF2,
   localparam int        IDXW     = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_MASK-1:0] req,
   input  logic [IDXW-1:0]     prom_idx,
   output logic                valid,
   output logic [7:0]          lo
);

   logic [NUM_MASK-1:0] grant;
   logic [NUM_MASK-1:0] below;   // below[k]: some lower index requests
   logic                prom_hit;

   assign below[0] = 1'b0;
   for (genvar k = 1; k < NUM_MASK; k++) begin : g_chain
      assign below[k] = below[k-1] | req[k-1];
   end

   assign prom_hit = req[prom_idx];

   for (genvar k = 0; k < NUM_MASK; k++) begin : g_grant
      assign grant[k] = prom_hit ? (prom_idx == IDXW'(k)) : (req[k] & ~below[k]);
   end

   always_comb begin
      lo = '0;
      for (int k = 0; k < NUM_MASK; k++) begin
         if (grant[k])
            lo = lo | vec_lo(MASK_TOP, k);
      end
   end

   assign valid = |grant;

   assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant))
      else $error("more than one maskable grant");
   assert_promoted_wins_R7: assert property (@(posedge clk) disable iff (rst)
      req[prom_idx] |-> (lo == vec_lo(MASK_TOP, int'(prom_idx))))
      else $error("promoted source did not win");
   assert_any_req_valid_R2: assert property (@(posedge clk) disable iff (rst)
      (|req) |-> valid)
      else $error("request without grant");

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int         NUM_MASK = 8,
   parameter int         NUM_NMI  = 3,
   parameter int         XPIN_IDX = 2,
   parameter logic [7:0] MASK_TOP = 8'hF2,
   parameter logic [7:0] NMI_TOP  = 8'hF8,
   parameter logic [7:0] VEC_PAGE = 8'hFF,
   localparam int        IDXW     = (NUM_MASK > 1) ? $clog2(NUM_MASK) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_NMI-1:0]  nmi_src,
   input  logic                ext_irq,
   input  logic                ext_pol,
   input  logic [NUM_MASK-2:0] per_flag,
   input  logic [NUM_MASK-2:0] per_en,
   input  logic                ccr_wr,
   input  logic                ccr_x_wd,
   input  logic                ccr_i_wd,
   input  logic                rti_en,
   input  logic                rti_x,
   input  logic                rti_i,
   input  logic                cpu_take,
   input  logic                prom_wr,
   input  logic [7:0]          prom_wdata,
   output logic [7:0]          prom_q,
   output logic                mask_x,
   output logic                mask_i,
   output logic                irq_valid,
   output logic                irq_nmi,
   output logic [15:0]         irq_vector
);

   // Elaboration-time parameter checks.
   if (NUM_MASK < 2) begin : g_bad_nmask
      $error("NUM_MASK must be at least 2");
   end
   if (NUM_NMI < 1 || XPIN_IDX >= NUM_NMI) begin : g_bad_nmi
      $error("XPIN_IDX must index a nonmaskable source");
   end
   if (MASK_TOP[0] || NMI_TOP[0]) begin : g_bad_align
      $error("vector low bytes must be even");
   end
   if (int'(MASK_TOP) < 2 * (NUM_MASK - 1)) begin : g_bad_span
      $error("maskable vectors underflow the page");
   end
   if (int'(NMI_TOP) - 2 * (NUM_NMI - 1) <= int'(MASK_TOP)) begin : g_bad_overlap
      $error("nonmaskable vectors must sit above maskable ones");
   end

   logic                x_q, i_q;
   logic                take_nmi, take_msk;
   logic [IDXW-1:0]     prom_idx;
   logic                ext_lvl;
   logic [NUM_MASK-1:0] msk_req;
   logic                nmi_valid, msk_valid;
   logic [7:0]          nmi_lo, msk_lo;
   logic                win_valid;
   logic [7:0]          win_lo;
   logic                valid_q, nmi_q;
   logic [15:0]         vec_q;

   assign take_nmi = cpu_take & valid_q & nmi_q;
   assign take_msk = cpu_take & valid_q & ~nmi_q;

   irq_mask_bits u_masks (
      .clk      (clk),
      .rst      (rst),
      .take_nmi (take_nmi),
      .take_msk (take_msk),
      .rti_en   (rti_en),
      .rti_x    (rti_x),
      .rti_i    (rti_i),
      .sw_wr    (ccr_wr),
      .sw_x     (ccr_x_wd),
      .sw_i     (ccr_i_wd),
      .x_q      (x_q),
      .i_q      (i_q)
   );

   irq_prom_reg #(.NUM_MASK(NUM_MASK), .MASK_TOP(MASK_TOP)) u_prom (
      .clk      (clk),
      .rst      (rst),
      .wr       (prom_wr),
      .wdata    (prom_wdata),
      .i_bit    (i_q),
      .prom_q   (prom_q),
      .prom_idx (prom_idx)
   );

   // Pin level with selectable polarity, then the global gate.
   assign ext_lvl = ext_pol ? ext_irq : ~ext_irq;
   assign msk_req = {per_flag & per_en, ext_lvl} & {NUM_MASK{~i_q}};

   irq_nmi_pick #(.NUM_NMI(NUM_NMI), .XPIN_IDX(XPIN_IDX), .NMI_TOP(NMI_TOP)) u_nmi (
      .clk   (clk),
      .rst   (rst),
      .src   (nmi_src),
      .x_bit (x_q),
      .valid (nmi_valid),
      .lo    (nmi_lo)
   );

   irq_msk_pick #(.NUM_MASK(NUM_MASK), .MASK_TOP(MASK_TOP)) u_msk (
      .clk      (clk),
      .rst      (rst),
      .req      (msk_req),
      .prom_idx (prom_idx),
      .valid    (msk_valid),
      .lo       (msk_lo)
   );

   assign win_valid = nmi_valid | msk_valid;
   assign win_lo    = nmi_valid ? nmi_lo : msk_lo;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         nmi_q   <= 1'b0;
         vec_q   <= '0;
      end else begin
         valid_q <= win_valid;
         nmi_q   <= nmi_valid;
         vec_q   <= win_valid ? {VEC_PAGE, win_lo} : 16'h0000;
      end
   end

   assign mask_x     = x_q;
   assign mask_i     = i_q;
   assign irq_valid  = valid_q;
   assign irq_nmi    = nmi_q;
   assign irq_vector = vec_q;

   assert_nmi_first_R1: assert property (@(posedge clk) disable iff (rst)
      nmi_valid |=> (irq_valid && irq_nmi))
      else $error("nonmaskable not presented");
   assert_i_blocks_R2: assert property (@(posedge clk) disable iff (rst)
      (mask_i && !nmi_valid) |=> !irq_valid)
      else $error("maskable passed while I set");
   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
      !irq_valid |-> (irq_vector == 16'h0000))
      else $error("vector not zero when idle");

endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NM = 8;
   localparam int NN = 3;
   localparam int XP = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NN-1:0] nmi_src = '0;
   logic          ext_irq = 1'b0, ext_pol = 1'b0;
   logic [NM-2:0] per_flag = '0, per_en = '0;
   logic          ccr_wr = 0, ccr_x_wd = 0, ccr_i_wd = 0;
   logic          rti_en = 0, rti_x = 0, rti_i = 0;
   logic          cpu_take = 0, prom_wr = 0;
   logic [7:0]    prom_wdata = '0;
   logic [7:0]    prom_q;
   logic          mask_x, mask_i, irq_valid, irq_nmi;
   logic [15:0]   irq_vector;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_arbiter u_irq_arbiter (
      .clk(clk), .rst(rst), .nmi_src(nmi_src), .ext_irq(ext_irq), .ext_pol(ext_pol),
      .per_flag(per_flag), .per_en(per_en), .ccr_wr(ccr_wr), .ccr_x_wd(ccr_x_wd),
      .ccr_i_wd(ccr_i_wd), .rti_en(rti_en), .rti_x(rti_x), .rti_i(rti_i),
      .cpu_take(cpu_take), .prom_wr(prom_wr), .prom_wdata(prom_wdata), .prom_q(prom_q),
      .mask_x(mask_x), .mask_i(mask_i), .irq_valid(irq_valid), .irq_nmi(irq_nmi),
      .irq_vector(irq_vector)
   );

   int   n_checks = 0;
   int   n_errors = 0;
   logic done = 1'b0;

   // Bench view of the state, kept from the requirements.
   logic       mx = 1'b1, mi = 1'b1;
   logic [7:0] mprom = 8'hF2;

   logic [17:0] exp_q[$];
   string       tag_q[$];

   task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected {valid, nmi, vector} from the requirements.
   function automatic logic [17:0] model();
      logic [NM-1:0] r;
      int p;
      for (int j = 0; j < NN; j++)
         if (nmi_src[j] && !(j == XP && mx))
            return {2'b11, 8'hFF, 8'(8'hF8 - 2 * j)};
      if (mi) return '0;
      r[0] = ext_pol ? ext_irq : ~ext_irq;
      for (int k = 1; k < NM; k++) r[k] = per_flag[k-1] & per_en[k-1];
      p = (8'hF2 - int'(mprom)) / 2;
      if (r[p]) return {2'b10, 8'hFF, mprom};
      for (int k = 0; k < NM; k++)
         if (r[k]) return {2'b10, 8'hFF, 8'(8'hF2 - 2 * k)};
      return '0;
   endfunction

   // Driver side: queue the expectation, wait for the monitor to consume it.
   task automatic expect_out(input string tag);
      exp_q.push_back(model());
      tag_q.push_back(tag);
      wait (exp_q.size() == 0);
   endtask

   // Monitor: compare one edge after each expectation is queued (R9).
   initial begin
      forever begin
         wait (exp_q.size() != 0);
         @(posedge clk);
         @(negedge clk);
         check({"R9 ", tag_q[0]}, {irq_valid, irq_nmi, irq_vector}, exp_q[0]);
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
   end

   task automatic ccr_write(input logic x, input logic i);
      @(negedge clk); ccr_x_wd = x; ccr_i_wd = i; ccr_wr = 1;
      @(negedge clk); ccr_wr = 0;
      mx = mx & x; mi = i;
   endtask

   task automatic prom_write(input logic [7:0] d);
      logic [7:0] lo;
      @(negedge clk); prom_wdata = d; prom_wr = 1;
      @(negedge clk); prom_wr = 0;
      lo = {d[7:1], 1'b0};
      if (mi && lo <= 8'hF2 && lo >= 8'(8'hF2 - 2 * (NM - 1))) mprom = lo;
   endtask

   task automatic take();
      logic [17:0] w;
      w = model();
      @(negedge clk); cpu_take = 1;
      @(negedge clk); cpu_take = 0;
      if (w[17] && w[16]) begin mx = 1; mi = 1; end
      else if (w[17]) mi = 1;
   endtask

   task automatic rti(input logic x, input logic i);
      @(negedge clk); rti_x = x; rti_i = i; rti_en = 1;
      @(negedge clk); rti_en = 0;
      mx = mx & x; mi = i;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R4: reset state
      check("R4 mask_x", 18'(mask_x), 18'd1);
      check("R4 mask_i", 18'(mask_i), 18'd1);
      check("R4 prom", 18'(prom_q), 18'h0F2);
      check("R4 valid", 18'(irq_valid), 18'd0);

      // R3: pin nonmaskable held off by X, other sources pass
      @(negedge clk); nmi_src = 3'b100; ext_pol = 1; ext_irq = 0;
      expect_out("R3 pin blocked by X");
      @(negedge clk); nmi_src = 3'b110;
      expect_out("R3 swi passes X");
      @(negedge clk); nmi_src = 3'b111;
      expect_out("R1 nmi order trap first");
      @(negedge clk); nmi_src = 3'b000; per_flag[2] = 1; per_en[2] = 1;
      expect_out("R2 I blocks maskable");

      // R8: promotion writes while I = 1
      prom_write(8'hE9);
      check("R8 prom bit0 reads 0", 18'(prom_q), 18'h0E8);
      prom_write(8'h10);
      check("R8 unmatched write ignored", 18'(prom_q), 18'h0E8);
      prom_write(8'hF4);
      check("R8 nmi vector write ignored", 18'(prom_q), 18'h0E8);

      // R5: software clears masks, cannot set X
      ccr_write(0, 0);
      check("R5 X cleared", 18'(mask_x), 18'd0);
      check("R5 I cleared", 18'(mask_i), 18'd0);
      expect_out("R2 flag and enable source 3");
      ccr_write(1, 0);
      check("R5 X not set by software", 18'(mask_x), 18'd0);
      prom_write(8'hEE);
      check("R8 write with I clear ignored", 18'(prom_q), 18'h0E8);

      // R7: promoted source beats higher-ordered one
      @(negedge clk); per_flag[4] = 1; per_en[4] = 1;
      expect_out("R7 promoted wins");
      @(negedge clk); per_en[4] = 0;
      expect_out("R2 local enable gates source 5");
      @(negedge clk); per_flag[0] = 1; per_en[0] = 1;
      expect_out("R7 index order source 1 over 3");
      @(negedge clk); per_flag[0] = 0;

      // R6: pin polarity
      @(negedge clk); ext_pol = 1; ext_irq = 1;
      expect_out("R6 active-high pin");
      @(negedge clk); ext_pol = 0; ext_irq = 1;
      expect_out("R6 active-low inactive");
      @(negedge clk); ext_irq = 0;
      expect_out("R6 active-low asserted");

      // R1/R5: pin nonmaskable with X clear, then take it
      @(negedge clk); nmi_src = 3'b100;
      expect_out("R1 nmi beats maskable");
      take();
      check("R5 nmi entry sets X", 18'(mask_x), 18'd1);
      check("R5 nmi entry sets I", 18'(mask_i), 18'd1);
      expect_out("R3 pin blocked after entry");

      // R10: return restore
      rti(0, 0);
      check("R10 X restored clear", 18'(mask_x), 18'd0);
      check("R10 I restored", 18'(mask_i), 18'd0);
      expect_out("R10 pin visible after return");
      rti(1, 1);
      check("R10 return cannot set X", 18'(mask_x), 18'd0);
      check("R10 return sets I", 18'(mask_i), 18'd1);

      // R5: maskable entry sets I only
      @(negedge clk); nmi_src = 3'b000;
      ccr_write(0, 0);
      expect_out("R6 pin maskable before take");
      take();
      check("R5 maskable entry sets I", 18'(mask_i), 18'd1);
      check("R5 maskable entry leaves X", 18'(mask_x), 18'd0);
      expect_out("R2 I set after maskable entry");

      // R8: promote pin-adjacent source while I = 1
      prom_write(8'hF0);
      check("R8 promote source 1", 18'(prom_q), 18'h0F0);

      finish_run();
   end
endmodule